// File: doc/BRIEF.md
# Gigabit Byte-to-Nibble DDR Bridge

This block converts between an 8-bit, single-data-rate byte interface running at 125 MHz and a 4-bit, double-data-rate nibble interface in each direction. That is the conversion a MAC needs to reach a gigabit PHY over a reduced pin count. On the transmit side the MAC supplies its own 125 MHz clock together with a byte, an enable and an error flag. The bridge registers the beat on the rising edge, then drives the low nibble during the high clock phase and the high nibble during the low clock phase. It also drives a single control line that carries the enable during the high phase and the enable XOR error during the low phase. The bridge forwards a transmit clock next to the data. That clock is either the byte clock itself, so data and clock edges coincide, or a supplied copy shifted by a quarter period, which places each clock edge in the middle of a data half.

On the receive side the PHY supplies the clock. The bridge samples a nibble and the control line on each edge of that clock, pairs the rising-edge sample with the falling-edge sample of the same cycle, and presents the rebuilt byte with valid and error flags on the following rising edge. Each clock domain has its own reset synchronizer, which asserts at once when the reset input goes low and releases on a clock edge. While in reset, both directions drive zeros.

Top module: `gmii_rgmii_bridge`

## Requirements
- R1: While the transmit byte clock is high, the nibble output carries bits 3:0 of the byte captured on the preceding rising edge of that clock.
- R2: While the transmit byte clock is low, the nibble output carries bits 7:4 of the byte captured on the preceding rising edge.
- R3: While the transmit byte clock is high, the transmit control line equals the enable captured on the preceding rising edge.
- R4: While the transmit byte clock is low, the transmit control line equals the captured enable XOR the captured error flag.
- R5: With the delay mode input at 0, the forwarded transmit clock follows the transmit byte clock.
- R6: With the delay mode input at 1, the forwarded transmit clock follows the supplied quadrature clock, which lags the byte clock by 90 degrees.
- R7: On receive, the nibble sampled on a rising edge of the receive clock becomes bits 3:0 and the nibble sampled on the next falling edge becomes bits 7:4. The rebuilt byte appears on the receive byte output at the rising edge that follows, one cycle after the rising-edge sample.
- R8: The receive valid flag equals the control line sampled on the rising edge, and the receive error flag equals that sample XOR the control line sampled on the falling edge.
- R9: A receive byte is presented only when a rising-edge sample taken after reset has been paired with its falling-edge sample. Otherwise, including throughout reset, the receive byte, valid and error outputs are all zero.
- R10: While reset is asserted, the nibble output is zero and the transmit control line is low in both clock phases, whatever the byte-side inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| tx_clk | input | 1 | 125 MHz transmit byte clock from the MAC side |
| tx_clk90 | input | 1 | Copy of tx_clk lagging by a quarter period |
| dly_mode | input | 1 | 0: forward tx_clk edge-aligned; 1: forward tx_clk90 |
| gmii_txd | input | 8 | Transmit byte |
| gmii_tx_en | input | 1 | Transmit enable |
| gmii_tx_er | input | 1 | Transmit error |
| rgmii_txc | output | 1 | Forwarded transmit clock |
| rgmii_txd | output | 4 | Transmit nibble, double data rate |
| rgmii_tx_ctl | output | 1 | Transmit control line, double data rate |
| rgmii_rxc | input | 1 | 125 MHz receive clock from the PHY side |
| rgmii_rxd | input | 4 | Receive nibble, double data rate |
| rgmii_rx_ctl | input | 1 | Receive control line, double data rate |
| gmii_rxd | output | 8 | Rebuilt receive byte |
| gmii_rx_dv | output | 1 | Receive valid |
| gmii_rx_er | output | 1 | Receive error |

## Verification
The bound checker checks the transmit half-cycle mapping on every edge: the low nibble and the enable at each falling edge, and the high nibble and the encoded control at each rising edge, both against the byte inputs of the cycle before. It also checks that the receive outputs stay zero after every cycle with no complete pair, and that reset holds the transmit pins quiet. The bench scenarios cover the rest. They check the forwarded clock phase in each delay mode at points inside the period. They also run a loopback in delayed mode, where every byte, enable and error pattern has to come back through the receive path exactly one cycle after its rising-edge sample. Only that end-to-end comparison shows that the nibble order and the control decoding on receive are the inverse of transmit.

// File: rtl/gmii_rgmii_bridge_pkg.sv
package gmii_rgmii_bridge_pkg;
  localparam int BYTE_W_DEF   = 8;
  localparam int RST_SYNC_DEF = 2;
endpackage

// File: rtl/gmii_rgmii_bridge_rst_sync.sv
module gmii_rgmii_bridge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gmii_rgmii_bridge_tx.sv
module gmii_rgmii_bridge_tx #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              clk90,
  input  logic              srst_n,
  input  logic              dly_mode,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              en_in,
  input  logic              er_in,
  output logic              fwd_clk,
  output logic [NIB_W-1:0]  nib_out,
  output logic              ctl_out
);
  // rising-edge stage: both halves of the beat
  logic [NIB_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic             ctl_hi_q, ctl_hi_d, ctl_lo_q, ctl_lo_d;
  // falling-edge stage: second half, held through the low phase
  logic [NIB_W-1:0] hi_n_q;
  logic             ctl_lo_n_q;

  always_comb begin
    lo_d     = byte_in[NIB_W-1:0];
    hi_d     = byte_in[BYTE_W-1:NIB_W];
    ctl_hi_d = en_in;
    ctl_lo_d = en_in ^ er_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      ctl_hi_q <= 1'b0;
      ctl_lo_q <= 1'b0;
    end else begin
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      ctl_hi_q <= ctl_hi_d;
      ctl_lo_q <= ctl_lo_d;
    end
  end

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hi_n_q     <= '0;
      ctl_lo_n_q <= 1'b0;
    end else begin
      hi_n_q     <= hi_q;
      ctl_lo_n_q <= ctl_lo_q;
    end
  end

  // output stage: clock-selected half, as a DDR output cell would
  assign nib_out = clk ? lo_q : hi_n_q;
  assign ctl_out = clk ? ctl_hi_q : ctl_lo_n_q;
  assign fwd_clk = dly_mode ? clk90 : clk;
endmodule

// File: rtl/gmii_rgmii_bridge_rx.sv
module gmii_rgmii_bridge_rx #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic              ctl_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              dv_out,
  output logic              er_out,
  output logic              paired
);
  logic [NIB_W-1:0]  rise_nib_q, fall_nib_q;
  logic              rise_ctl_q, fall_ctl_q;
  logic              live_q, live_d;
  logic              pair_q;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              dv_q, dv_d, er_q, er_d;

  always_comb begin
    live_d = 1'b1;
    if (pair_q) begin
      byte_d = {fall_nib_q, rise_nib_q};
      dv_d   = rise_ctl_q;
      er_d   = rise_ctl_q ^ fall_ctl_q;
    end else begin
      byte_d = '0;
      dv_d   = 1'b0;
      er_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rise_nib_q <= '0;
      rise_ctl_q <= 1'b0;
      live_q     <= 1'b0;
      byte_q     <= '0;
      dv_q       <= 1'b0;
      er_q       <= 1'b0;
    end else begin
      rise_nib_q <= nib_in;
      rise_ctl_q <= ctl_in;
      live_q     <= live_d;
      byte_q     <= byte_d;
      dv_q       <= dv_d;
      er_q       <= er_d;
    end
  end

  // falling edge completes the pair started by the last rising edge
  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fall_nib_q <= '0;
      fall_ctl_q <= 1'b0;
      pair_q     <= 1'b0;
    end else begin
      fall_nib_q <= nib_in;
      fall_ctl_q <= ctl_in;
      pair_q     <= live_q;
    end
  end

  assign byte_out = byte_q;
  assign dv_out   = dv_q;
  assign er_out   = er_q;
  assign paired   = pair_q;
endmodule

// File: rtl/gmii_rgmii_bridge.sv
module gmii_rgmii_bridge
  import gmii_rgmii_bridge_pkg::*;
#(
  parameter int BYTE_W    = BYTE_W_DEF,
  parameter int RST_SYNC  = RST_SYNC_DEF,
  localparam int NIB_W    = BYTE_W / 2
) (
  input  logic              rst_n,
  input  logic              tx_clk,
  input  logic              tx_clk90,
  input  logic              dly_mode,
  input  logic [BYTE_W-1:0] gmii_txd,
  input  logic              gmii_tx_en,
  input  logic              gmii_tx_er,
  output logic              rgmii_txc,
  output logic [NIB_W-1:0]  rgmii_txd,
  output logic              rgmii_tx_ctl,
  input  logic              rgmii_rxc,
  input  logic [NIB_W-1:0]  rgmii_rxd,
  input  logic              rgmii_rx_ctl,
  output logic [BYTE_W-1:0] gmii_rxd,
  output logic              gmii_rx_dv,
  output logic              gmii_rx_er
);
  logic tx_rst_q;
  logic rx_rst_q;
  logic rx_paired;

  gmii_rgmii_bridge_rst_sync #(.STAGES(RST_SYNC)) u_tx_rst (
    .clk(tx_clk), .arst_n(rst_n), .srst_n(tx_rst_q)
  );

  gmii_rgmii_bridge_rst_sync #(.STAGES(RST_SYNC)) u_rx_rst (
    .clk(rgmii_rxc), .arst_n(rst_n), .srst_n(rx_rst_q)
  );

  gmii_rgmii_bridge_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk(tx_clk), .clk90(tx_clk90), .srst_n(tx_rst_q), .dly_mode(dly_mode),
    .byte_in(gmii_txd), .en_in(gmii_tx_en), .er_in(gmii_tx_er),
    .fwd_clk(rgmii_txc), .nib_out(rgmii_txd), .ctl_out(rgmii_tx_ctl)
  );

  gmii_rgmii_bridge_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(rgmii_rxc), .srst_n(rx_rst_q), .nib_in(rgmii_rxd), .ctl_in(rgmii_rx_ctl),
    .byte_out(gmii_rxd), .dv_out(gmii_rx_dv), .er_out(gmii_rx_er),
    .paired(rx_paired)
  );
endmodule

// File: rtl/gmii_rgmii_bridge_chk.sv
module gmii_rgmii_bridge_chk #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input logic              rst_n,
  input logic              tx_clk,
  input logic              tx_rst_q,
  input logic [BYTE_W-1:0] gmii_txd,
  input logic              gmii_tx_en,
  input logic              gmii_tx_er,
  input logic [NIB_W-1:0]  rgmii_txd,
  input logic              rgmii_tx_ctl,
  input logic              rgmii_rxc,
  input logic              rx_rst_q,
  input logic              rx_paired,
  input logic [BYTE_W-1:0] gmii_rxd,
  input logic              gmii_rx_dv,
  input logic              gmii_rx_er
);
  // Byte-side inputs are expected to change on falling edges of tx_clk.
  assert_rise_nibble_R1: assert property (@(negedge tx_clk) disable iff (!tx_rst_q)
    $past(tx_rst_q) |-> rgmii_txd == gmii_txd[NIB_W-1:0]);

  assert_rise_ctl_R3: assert property (@(negedge tx_clk) disable iff (!tx_rst_q)
    $past(tx_rst_q) |-> rgmii_tx_ctl == gmii_tx_en);

  assert_fall_nibble_R2: assert property (@(posedge tx_clk) disable iff (!tx_rst_q)
    $past(tx_rst_q) |-> rgmii_txd == $past(gmii_txd[BYTE_W-1:NIB_W]));

  assert_fall_ctl_R4: assert property (@(posedge tx_clk) disable iff (!tx_rst_q)
    $past(tx_rst_q) |-> rgmii_tx_ctl == ($past(gmii_tx_en) ^ $past(gmii_tx_er)));

  assert_unpaired_quiet_R9: assert property (@(posedge rgmii_rxc) disable iff (!rx_rst_q)
    !rx_paired |=> (gmii_rxd == '0 && !gmii_rx_dv && !gmii_rx_er));

  always @(negedge tx_clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (rgmii_txd == '0 && !rgmii_tx_ctl);
    end
  end
endmodule

bind gmii_rgmii_bridge gmii_rgmii_bridge_chk #(.BYTE_W(BYTE_W)) u_chk (
  .rst_n(rst_n), .tx_clk(tx_clk), .tx_rst_q(tx_rst_q),
  .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en), .gmii_tx_er(gmii_tx_er),
  .rgmii_txd(rgmii_txd), .rgmii_tx_ctl(rgmii_tx_ctl),
  .rgmii_rxc(rgmii_rxc), .rx_rst_q(rx_rst_q), .rx_paired(rx_paired),
  .gmii_rxd(gmii_rxd), .gmii_rx_dv(gmii_rx_dv), .gmii_rx_er(gmii_rx_er)
);

// File: tb/gmii_rgmii_bridge_tb.sv
module gmii_rgmii_bridge_tb_top;
  localparam int CLK_PERIOD = 8;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int QTR        = CLK_PERIOD / 4;

  logic       rst_n, tx_clk, tx_clk90, ext_rxc, dly_mode, loop_on;
  logic [7:0] gmii_txd;
  logic       gmii_tx_en, gmii_tx_er;
  logic       rgmii_txc, rgmii_tx_ctl;
  logic [3:0] rgmii_txd;
  logic [3:0] ext_rxd;
  logic       ext_ctl;
  logic       rx_c, rx_ctl;
  logic [3:0] rx_d;
  logic [7:0] gmii_rxd;
  logic       gmii_rx_dv, gmii_rx_er;

  int n_cmp = 0;
  int n_bad = 0;
  bit sb_on = 0;
  logic [9:0] exp_q [$];

  assign rx_c   = loop_on ? rgmii_txc    : ext_rxc;
  assign rx_d   = loop_on ? rgmii_txd    : ext_rxd;
  assign rx_ctl = loop_on ? rgmii_tx_ctl : ext_ctl;

  gmii_rgmii_bridge dut_i (
    .rst_n(rst_n), .tx_clk(tx_clk), .tx_clk90(tx_clk90), .dly_mode(dly_mode),
    .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en), .gmii_tx_er(gmii_tx_er),
    .rgmii_txc(rgmii_txc), .rgmii_txd(rgmii_txd), .rgmii_tx_ctl(rgmii_tx_ctl),
    .rgmii_rxc(rx_c), .rgmii_rxd(rx_d), .rgmii_rx_ctl(rx_ctl),
    .gmii_rxd(gmii_rxd), .gmii_rx_dv(gmii_rx_dv), .gmii_rx_er(gmii_rx_er)
  );

  initial begin tx_clk = 0; forever #(HALF) tx_clk = ~tx_clk; end
  initial begin tx_clk90 = 0; #(QTR); forever #(HALF) tx_clk90 = ~tx_clk90; end
  initial begin ext_rxc = 0; #(QTR); forever #(HALF) ext_rxc = ~ext_rxc; end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // transmit-only beat with checks in both phases (edge-aligned mode)
  task automatic tx_direct(input logic [7:0] d, input logic en, input logic er);
    @(negedge tx_clk);
    gmii_txd = d; gmii_tx_en = en; gmii_tx_er = er;
    @(posedge tx_clk); #(QTR);
    check("R1 low nibble in high phase", {12'd0, rgmii_txd}, {12'd0, d[3:0]});
    check("R3 ctl in high phase", {15'd0, rgmii_tx_ctl}, {15'd0, en});
    @(negedge tx_clk); #(QTR);
    check("R2 high nibble in low phase", {12'd0, rgmii_txd}, {12'd0, d[7:4]});
    check("R4 ctl in low phase", {15'd0, rgmii_tx_ctl}, {15'd0, en ^ er});
  endtask

  // loopback driver: one beat per cycle, expectation queued
  task automatic send(input logic [7:0] d, input logic en, input logic er);
    @(negedge tx_clk);
    gmii_txd = d; gmii_tx_en = en; gmii_tx_er = er;
    if (sb_on) exp_q.push_back({en, er, d});
  endtask

  // monitor: byte sent at a falling edge returns 18 ns later (R7, R8)
  always @(negedge rx_c) begin
    if (sb_on && exp_q.size() >= 3) begin
      logic [9:0] e;
      e = exp_q.pop_front();
      check("R7 loopback byte", {8'd0, gmii_rxd}, {8'd0, e[7:0]});
      check("R8 loopback valid/error", {14'd0, gmii_rx_dv, gmii_rx_er}, {14'd0, e[9], e[8]});
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1; dly_mode = 0; loop_on = 0;
    gmii_txd = 8'hFF; gmii_tx_en = 1; gmii_tx_er = 1;
    ext_rxd = 4'hF; ext_ctl = 1;
    #1 rst_n = 0;
    repeat (4) @(posedge tx_clk);
    #(QTR);
    check("R10 reset nibble high phase", {12'd0, rgmii_txd}, 16'd0);
    check("R10 reset ctl high phase", {15'd0, rgmii_tx_ctl}, 16'd0);
    check("R9 reset rx outputs", {6'd0, gmii_rxd, gmii_rx_dv, gmii_rx_er}, 16'd0);
    @(negedge tx_clk); #(QTR);
    check("R10 reset nibble low phase", {12'd0, rgmii_txd}, 16'd0);
    check("R10 reset ctl low phase", {15'd0, rgmii_tx_ctl}, 16'd0);
    @(negedge tx_clk);
    rst_n = 1;
    gmii_txd = 8'h00; gmii_tx_en = 0; gmii_tx_er = 0;
    ext_ctl = 0; ext_rxd = 4'h0;
    repeat (5) @(negedge tx_clk);

    // R5: edge-aligned forwarding
    @(posedge tx_clk);
    #1 check("R5 txc at +1", {15'd0, rgmii_txc}, 16'd1);
    #2 check("R5 txc at +3", {15'd0, rgmii_txc}, 16'd1);
    #2 check("R5 txc at +5", {15'd0, rgmii_txc}, 16'd0);
    #2 check("R5 txc at +7", {15'd0, rgmii_txc}, 16'd0);

    tx_direct(8'hA5, 1'b1, 1'b0);
    tx_direct(8'h3C, 1'b1, 1'b1);
    tx_direct(8'h00, 1'b0, 1'b1);
    tx_direct(8'hF0, 1'b0, 1'b0);
    tx_direct(8'h69, 1'b1, 1'b0);

    // R6: quadrature forwarding
    @(negedge tx_clk); dly_mode = 1;
    @(posedge tx_clk);
    #1 check("R6 txc at +1", {15'd0, rgmii_txc}, 16'd0);
    #2 check("R6 txc at +3", {15'd0, rgmii_txc}, 16'd1);
    #2 check("R6 txc at +5", {15'd0, rgmii_txc}, 16'd1);
    #2 check("R6 txc at +7", {15'd0, rgmii_txc}, 16'd0);

    // loopback through the receive path, clock centred by the delay
    @(negedge tx_clk);
    gmii_txd = 8'h00; gmii_tx_en = 0; gmii_tx_er = 0;
    loop_on = 1;
    repeat (4) send(8'h00, 1'b0, 1'b0);
    sb_on = 1;
    repeat (3) send(8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) send(8'h55, 1'b1, 1'b0);
    send(8'hD5, 1'b1, 1'b0);
    for (int i = 0; i < 32; i++) send(8'(i * 37 + 11), 1'b1, (i == 13));
    send(8'h0F, 1'b0, 1'b1);
    send(8'h0F, 1'b0, 1'b1);
    send(8'hC3, 1'b0, 1'b0);
    begin
      logic [7:0] lf;
      lf = 8'hE1;
      for (int i = 0; i < 48; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        send(lf, lf[0] | lf[3], lf[6] & lf[1]);
      end
    end
    repeat (4) send(8'h00, 1'b0, 1'b0);
    @(negedge tx_clk);
    check("R7 queue drained to pipeline depth", 16'(exp_q.size()), 16'd2);
    finish_run();
  end
endmodule